// File: doc/BRIEF.md
# Two-Sided Mailbox with Possession Hand-off

This block is a small 256-bit scratch area, eight 32-bit words, shared by a requesting function and a managing function. Each side has its own register port with a write strobe, a word address, write data and read data. A single possession flag decides which side may write. After reset the requester holds the mailbox. It fills the payload words, then writes the top word, which acts as both message header and doorbell. That write hands possession to the manager. The manager reads the request, writes its answer and releases the mailbox by writing the top word with bit 31 clear.

Bit 31 of the top word always shows the live possession flag on both ports: 1 means the manager holds the mailbox, 0 means the requester does. The other header fields are stored as written. Their layout is type in [2:0], version in [5:3], direction in bit 7, status in [15:8] and reset-request in bit 24. A separate reset-view input models a function reset in progress: while it is high, every read returns all ones and no write is taken.

Reads are combinational from the addressed word. A write is visible on the following cycle.

Top module: `shm_mailbox`

## Requirements
- R1: When rst_n is low at a clock edge, all eight words become zero, the requester holds the mailbox (pf_owns = 0) and rq_err is cleared.
- R2: A requester write to word 7 while the requester holds the mailbox stores the data and sets pf_owns to 1 on the next cycle.
- R3: A requester write to words 0 to 6 while the requester holds the mailbox stores the data and leaves pf_owns unchanged.
- R4: Outside the reset view, reading word 7 on either port returns pf_owns in bit 31 and the stored bits [30:0]. Reading words 0 to 6 returns the stored word.
- R5: While fn_reset_view is high, both read ports return 0xFFFFFFFF, and writes from either side change no word, no ownership and no error flag.
- R6: A manager write to word 7 while the manager holds the mailbox stores the data. If bit 31 of the data is 0, pf_owns returns to 0 on the next cycle. If bit 31 is 1, pf_owns stays 1.
- R7: A requester write while the manager holds the mailbox changes no word and sets rq_err. rq_err then stays at 1 until rst_n.
- R8: A manager write while the requester holds the mailbox changes no word and no ownership. A manager write to words 0 to 6 while it holds the mailbox stores the data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fn_reset_view | input | 1 | Function reset in progress: reads return all ones, writes are dropped |
| rq_wr_en | input | 1 | Requester write strobe |
| rq_addr | input | 3 | Requester word address |
| rq_wdata | input | 32 | Requester write data |
| rq_rdata | output | 32 | Requester read data of the addressed word |
| pf_wr_en | input | 1 | Manager write strobe |
| pf_addr | input | 3 | Manager word address |
| pf_wdata | input | 32 | Manager write data |
| pf_rdata | output | 32 | Manager read data of the addressed word |
| pf_owns | output | 1 | Possession flag, 1 when the manager holds the mailbox |
| rq_err | output | 1 | Sticky flag for a requester write refused by possession |

## Verification
The assertions check these rules on every cycle:
- the ownership hand-offs on top-word writes in both directions;
- the live owner bit in the header read-back;
- the all-ones reset view;
- that the error flag, once set, stays set;
- the reset state.

Only the bench's scenarios show that payload words keep their contents across refused writes, manager writes made without possession, and reset-view periods. The bench compares both read ports against a behavioural model every clock and walks a full request, response and teardown exchange to show the header fields round-trip intact.

// File: rtl/mbox_pkg.sv
// Package: shared constants and the header-word layout of the mailbox.
// Assumes a 32-bit word when the header struct is used.
package mbox_pkg;
    localparam int HDR_W = 32;

    typedef struct packed {
        logic       owner;      // [31] 1 = manager holds the mailbox
        logic [5:0] rsvd_hi;    // [30:25]
        logic       rst_req;    // [24]
        logic [7:0] rsvd_mid;   // [23:16]
        logic [7:0] status;     // [15:8]
        logic       dir;        // [7]
        logic       rsvd_lo;    // [6]
        logic [2:0] version;    // [5:3]
        logic [2:0] mtype;      // [2:0]
    } hdr_t;
endpackage

// File: rtl/mbox_owner.sv
// Module: possession flag and sticky refusal flag.
// Decides which side's write is accepted this cycle. It assumes the two
// accept terms are mutually exclusive, because they depend on opposite
// values of the flag.
module mbox_owner (
    input  logic clk,
    input  logic rst_n,
    input  logic fn_reset_view,
    input  logic rq_wr,
    input  logic rq_top,
    input  logic pf_wr,
    input  logic pf_top,
    input  logic pf_own_bit,
    output logic rq_accept,
    output logic pf_accept,
    output logic pf_owns,
    output logic rq_err
);
    logic owns_q;
    logic err_q;

    // Accept a write only from the side that currently holds the mailbox.
    always_comb begin
        rq_accept = rq_wr & ~fn_reset_view & ~owns_q;
        pf_accept = pf_wr & ~fn_reset_view &  owns_q;
    end

    // Track possession and latch refused requester writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owns_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (rq_accept && rq_top)
                owns_q <= 1'b1;
            else if (pf_accept && pf_top && !pf_own_bit)
                owns_q <= 1'b0;
            if (rq_wr && !fn_reset_view && owns_q)
                err_q <= 1'b1;
        end
    end

    assign pf_owns = owns_q;
    assign rq_err  = err_q;
endmodule

// File: rtl/mbox_store.sv
// Module: word storage, one register per word.
// Assumes at most one of the two write enables is high in a cycle; the
// requester has precedence if both were ever high.
module mbox_store #(
    parameter int WORDS = 8,
    parameter int DW    = 32,
    parameter int AW    = $clog2(WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rq_we,
    input  logic [AW-1:0]       rq_addr,
    input  logic [DW-1:0]       rq_wdata,
    input  logic                pf_we,
    input  logic [AW-1:0]       pf_addr,
    input  logic [DW-1:0]       pf_wdata,
    output logic [WORDS*DW-1:0] words
);
    for (genvar i = 0; i < WORDS; i++) begin : g_word
        logic [DW-1:0] word_q;

        // Load this word from whichever side addresses it with an accepted write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else if (rq_we && rq_addr == AW'(i))
                word_q <= rq_wdata;
            else if (pf_we && pf_addr == AW'(i))
                word_q <= pf_wdata;
        end

        assign words[i*DW +: DW] = word_q;
    end
endmodule

// File: rtl/mbox_rdview.sv
// Module: read view of one port.
// Returns all ones during the reset view. Otherwise it returns the
// addressed word, with the live possession flag inserted in the top bit
// of the header word.
module mbox_rdview #(
    parameter int WORDS = 8,
    parameter int DW    = 32,
    parameter int AW    = $clog2(WORDS)
) (
    input  logic [WORDS*DW-1:0] words,
    input  logic [AW-1:0]       addr,
    input  logic                owns,
    input  logic                fn_reset_view,
    output logic [DW-1:0]       rdata
);
    localparam logic [AW-1:0] TOP_IDX = AW'(WORDS - 1);

    logic [DW-1:0] word;
    logic [DW-1:0] hdr_view;

    // Select the addressed word.
    always_comb word = words[addr*DW +: DW];

    if (DW == mbox_pkg::HDR_W) begin : g_hdr_struct
        // Overlay the owner field through the header layout.
        always_comb begin
            mbox_pkg::hdr_t h;
            h        = mbox_pkg::hdr_t'(word);
            h.owner  = owns;
            hdr_view = DW'(h);
        end
    end else begin : g_hdr_plain
        // Overlay the owner flag on the top bit of a non-standard width.
        always_comb hdr_view = {owns, word[DW-2:0]};
    end

    // Apply the reset view, then the header overlay.
    always_comb begin
        if (fn_reset_view)
            rdata = '1;
        else if (addr == TOP_IDX)
            rdata = hdr_view;
        else
            rdata = word;
    end
endmodule

// File: rtl/shm_mailbox.sv
// Module: top of the two-sided mailbox.
// Ties together possession control, word storage and one read view per
// port. Assumes both sides share clk and rst_n.
module shm_mailbox #(
    parameter int WORDS = 8,
    parameter int DW    = 32,
    parameter int AW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fn_reset_view,
    input  logic          rq_wr_en,
    input  logic [AW-1:0] rq_addr,
    input  logic [DW-1:0] rq_wdata,
    output logic [DW-1:0] rq_rdata,
    input  logic          pf_wr_en,
    input  logic [AW-1:0] pf_addr,
    input  logic [DW-1:0] pf_wdata,
    output logic [DW-1:0] pf_rdata,
    output logic          pf_owns,
    output logic          rq_err
);
    localparam logic [AW-1:0] TOP_IDX = AW'(WORDS - 1);

    logic                rq_accept;
    logic                pf_accept;
    logic [WORDS*DW-1:0] words;

    mbox_owner u_owner (
        .clk           (clk),
        .rst_n         (rst_n),
        .fn_reset_view (fn_reset_view),
        .rq_wr         (rq_wr_en),
        .rq_top        (rq_addr == TOP_IDX),
        .pf_wr         (pf_wr_en),
        .pf_top        (pf_addr == TOP_IDX),
        .pf_own_bit    (pf_wdata[DW-1]),
        .rq_accept     (rq_accept),
        .pf_accept     (pf_accept),
        .pf_owns       (pf_owns),
        .rq_err        (rq_err)
    );

    mbox_store #(.WORDS(WORDS), .DW(DW), .AW(AW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rq_we    (rq_accept),
        .rq_addr  (rq_addr),
        .rq_wdata (rq_wdata),
        .pf_we    (pf_accept),
        .pf_addr  (pf_addr),
        .pf_wdata (pf_wdata),
        .words    (words)
    );

    mbox_rdview #(.WORDS(WORDS), .DW(DW), .AW(AW)) u_rq_view (
        .words         (words),
        .addr          (rq_addr),
        .owns          (pf_owns),
        .fn_reset_view (fn_reset_view),
        .rdata         (rq_rdata)
    );

    mbox_rdview #(.WORDS(WORDS), .DW(DW), .AW(AW)) u_pf_view (
        .words         (words),
        .addr          (pf_addr),
        .owns          (pf_owns),
        .fn_reset_view (fn_reset_view),
        .rdata         (pf_rdata)
    );
endmodule

// File: rtl/mbox_checker.sv
// Module: protocol checker for shm_mailbox, attached through bind.
// Observes the ports only.
module mbox_checker #(
    parameter int WORDS = 8,
    parameter int DW    = 32,
    parameter int AW    = $clog2(WORDS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fn_reset_view,
    input logic          rq_wr_en,
    input logic [AW-1:0] rq_addr,
    input logic [DW-1:0] rq_rdata,
    input logic          pf_wr_en,
    input logic [AW-1:0] pf_addr,
    input logic [DW-1:0] pf_wdata,
    input logic [DW-1:0] pf_rdata,
    input logic          pf_owns,
    input logic          rq_err
);
    localparam logic [AW-1:0] TOP_IDX = AW'(WORDS - 1);

    AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (!pf_owns && !rq_err)); // R1
    AST_DOORBELL_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_wr_en && rq_addr == TOP_IDX && !pf_owns && !fn_reset_view) |=> pf_owns); // R2
    AST_PAYLOAD_KEEPS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_wr_en && rq_addr != TOP_IDX && !pf_owns) |=> !pf_owns); // R3
    AST_OWNER_BIT_RQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!fn_reset_view && rq_addr == TOP_IDX) |-> (rq_rdata[DW-1] == pf_owns)); // R4
    AST_OWNER_BIT_PF: assert property (@(posedge clk) disable iff (!rst_n)
        (!fn_reset_view && pf_addr == TOP_IDX) |-> (pf_rdata[DW-1] == pf_owns)); // R4
    AST_RESET_VIEW_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        fn_reset_view |-> (&rq_rdata && &pf_rdata)); // R5
    AST_VIEW_FREEZES_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        fn_reset_view |=> $stable(pf_owns)); // R5
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_wr_en && pf_addr == TOP_IDX && !pf_wdata[DW-1] && pf_owns && !fn_reset_view) |=> !pf_owns); // R6
    AST_KEEP_ON_OWNER_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_wr_en && pf_wdata[DW-1] && pf_owns && !rq_wr_en) |=> pf_owns); // R6
    AST_REFUSE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_wr_en && pf_owns && !fn_reset_view) |=> rq_err); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rq_err |=> rq_err); // R7
    AST_PF_NO_GRAB: assert property (@(posedge clk) disable iff (!rst_n)
        (!pf_owns && !rq_wr_en) |=> !pf_owns); // R8
endmodule

bind shm_mailbox mbox_checker #(.WORDS(WORDS), .DW(DW), .AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fn_reset_view (fn_reset_view),
    .rq_wr_en      (rq_wr_en),
    .rq_addr       (rq_addr),
    .rq_rdata      (rq_rdata),
    .pf_wr_en      (pf_wr_en),
    .pf_addr       (pf_addr),
    .pf_wdata      (pf_wdata),
    .pf_rdata      (pf_rdata),
    .pf_owns       (pf_owns),
    .rq_err        (rq_err)
);

// File: tb/shm_mailbox_test.sv
module shm_mailbox_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fn_reset_view = 1'b0;
    logic        rq_wr_en = 1'b0;
    logic [2:0]  rq_addr = '0;
    logic [31:0] rq_wdata = '0;
    logic [31:0] rq_rdata;
    logic        pf_wr_en = 1'b0;
    logic [2:0]  pf_addr = '0;
    logic [31:0] pf_wdata = '0;
    logic [31:0] pf_rdata;
    logic        pf_owns;
    logic        rq_err;

    int          n_vec = 0;
    int          n_bad = 0;
    logic [31:0] m_mem [8];
    bit          m_owns = 1'b0;
    bit          m_err = 1'b0;
    bit          m_rst = 1'b1;

    always #4 clk = ~clk;

    shm_mailbox uut (
        .clk(clk), .rst_n(rst_n), .fn_reset_view(fn_reset_view),
        .rq_wr_en(rq_wr_en), .rq_addr(rq_addr), .rq_wdata(rq_wdata), .rq_rdata(rq_rdata),
        .pf_wr_en(pf_wr_en), .pf_addr(pf_addr), .pf_wdata(pf_wdata), .pf_rdata(pf_rdata),
        .pf_owns(pf_owns), .rq_err(rq_err)
    );

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        if (fn_reset_view) return 32'hFFFF_FFFF;
        if (a == 3'd7) return {m_owns, m_mem[7][30:0]};
        return m_mem[a];
    endfunction

    task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive, compare against the model, advance the model.
    task automatic step(input string tag, input bit rst, input bit view,
                        input bit rw, input logic [2:0] ra, input logic [31:0] rd,
                        input bit pw, input logic [2:0] pa, input logic [31:0] pd);
        bit o;
        @(negedge clk);
        rst_n = ~rst; fn_reset_view = view;
        rq_wr_en = rw; rq_addr = ra; rq_wdata = rd;
        pf_wr_en = pw; pf_addr = pa; pf_wdata = pd;
        #1;
        n_vec++;
        if (!m_rst) begin
            cmp(tag, "rq_rdata", rq_rdata, exp_read(ra));
            cmp(tag, "pf_rdata", pf_rdata, exp_read(pa));
            cmp(tag, "pf_owns", {31'd0, pf_owns}, {31'd0, m_owns});
            cmp(tag, "rq_err", {31'd0, rq_err}, {31'd0, m_err});
        end
        @(posedge clk);
        #1;
        o = m_owns;
        if (rst) begin
            for (int i = 0; i < 8; i++) m_mem[i] = '0;
            m_owns = 1'b0; m_err = 1'b0; m_rst = 1'b0;
        end else if (!view) begin
            if (rw) begin
                if (o) m_err = 1'b1;
                else begin
                    m_mem[ra] = rd;
                    if (ra == 3'd7) m_owns = 1'b1;
                end
            end
            if (pw && o) begin
                m_mem[pa] = pd;
                if (pa == 3'd7 && !pd[31]) m_owns = 1'b0;
            end
        end
    endtask

    task automatic idle(input string tag, input logic [2:0] ra, input logic [2:0] pa);
        step(tag, 0, 0, 0, ra, '0, 0, pa, '0);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        step("R1", 1, 0, 0, 0, '0, 0, 0, '0);
        step("R1", 1, 0, 0, 0, '0, 0, 0, '0);
        // R1: every word reads zero and requester holds the mailbox after reset
        for (int i = 0; i < 8; i++) idle("R1", 3'(i), 3'(7 - i));
        // R3: fill payload words, no ownership change
        for (int i = 0; i < 7; i++)
            step("R3", 0, 0, 1, 3'(i), 32'hA5A5_0000 + 32'(i * 32'h1111), 0, 0, '0);
        for (int i = 0; i < 7; i++) idle("R3", 3'(i), 3'(i));
        // R8: manager write without possession is dropped
        step("R8", 0, 0, 0, 0, '0, 1, 3'd2, 32'hDEAD_BEEF);
        idle("R8", 3'd2, 3'd2);
        step("R8", 0, 0, 0, 0, '0, 1, 3'd7, 32'h0000_0000);
        idle("R8", 3'd7, 3'd7);
        // R2: doorbell write with type 1 and reset-request flag, owner bit clear in data
        step("R2", 0, 0, 1, 3'd7, 32'h0100_0001, 0, 0, '0);
        idle("R2", 3'd7, 3'd7);
        // R4: header read-back shows owner in bit 31
        idle("R4", 3'd7, 3'd0);
        // R7: requester write refused, error sticky
        step("R7", 0, 0, 1, 3'd1, 32'h1234_5678, 0, 0, '0);
        idle("R7", 3'd1, 3'd1);
        // R8: manager writes payload while owning
        step("R8", 0, 0, 0, 0, '0, 1, 3'd4, 32'hCAFE_F00D);
        idle("R8", 3'd4, 3'd4);
        // R6: top write with bit 31 set keeps possession
        step("R6", 0, 0, 0, 0, '0, 1, 3'd7, 32'h8000_0081);
        idle("R6", 3'd7, 3'd7);
        // R5: reset view reads all ones, writes dropped
        step("R5", 0, 1, 1, 3'd3, 32'h0BAD_0BAD, 1, 3'd7, 32'h0000_0081);
        step("R5", 0, 1, 0, 3'd7, '0, 1, 3'd5, 32'h5555_5555);
        idle("R5", 3'd3, 3'd5);
        idle("R5", 3'd7, 3'd7);
        // R6: response with status 3, direction response, bit 31 clear releases
        step("R6", 0, 0, 0, 0, '0, 1, 3'd7, 32'h0000_0381);
        idle("R6", 3'd7, 3'd7);
        // R7: error stays set after release
        idle("R7", 3'd0, 3'd0);
        // R2: teardown doorbell type 2
        step("R2", 0, 0, 1, 3'd7, 32'h0000_0002, 0, 0, '0);
        idle("R2", 3'd7, 3'd7);
        step("R6", 0, 0, 0, 0, '0, 1, 3'd7, 32'h0000_0082);
        idle("R6", 3'd7, 3'd7);
        // Mixed traffic from an LFSR
        lf = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step("R4", 0, (lf[15:12] == 4'hF), lf[0], lf[3:1], {lf, ~lf},
                 lf[4], lf[7:5], {lf[8], 15'(lf), lf});
        end
        // R1: reset again clears everything
        step("R1", 1, 0, 0, 0, '0, 0, 0, '0);
        for (int i = 0; i < 8; i++) idle("R1", 3'(i), 3'(i));
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule